// File: doc/BRIEF.md
# Set/Clear Interrupt Control Unit

This block keeps an 18-bit control word that software changes through two write addresses. A write to one address turns on the bits that are 1 in the data. A write to the other address turns those bits off. Software can therefore change single bits without a read-modify-write cycle. Either address reads back the whole word.

The control word steers two interrupt sources. Each source has a source vector and an enable mask. The block decides which of the two hardware interrupt lines each source raises, and it can merge both onto the first line. On request, the block also builds the 64-bit status word that a delayed-interrupt DMA engine sends out. That word can be masked by the enables, its two halves can be exchanged, and its bytes can be reversed for little-endian targets. Two stored hint bits are passed through to the bus master and have no effect inside the block.

Top module: `irqctl_top`

## Requirements
- R1: After synchronous reset the control word is 0x10200 (bit 16 word-swap and bit 9 are 1), both interrupt lines are low, the valid strobe is low and both hints are low.
- R2: A write to offset 0x8 ORs wr_data[17:0] into the control word, and a write to offset 0xC clears the bits set in wr_data[17:0]; the change is visible on the next cycle. Writes to any other offset, and data bits 31:18, have no effect.
- R3: Reading offset 0x8 or 0xC returns the control word zero-extended to 32 bits; any other read offset returns zero.
- R4: With bit 12 (route) at 0, irq1 is high when bit 15 is 1 and src1 AND mask1 is nonzero, and irq2 is high when bit 14 is 1 and src2 AND mask2 is nonzero; both lines are registered and follow their inputs one cycle later.
- R5: With bit 12 at 1, irq1 is the OR of both enabled, masked sources and irq2 stays low.
- R6: With bit 11 at 1 each status half is its source ANDed with its mask; with bit 11 at 0 it is the raw source.
- R7: Before any swap, bits 63:32 hold the source-1 half and bits 31:0 the source-2 half; with bit 16 at 1 the two halves are exchanged.
- R8: With bit 13 at 1 the bytes inside each 32-bit half are reversed, after masking and swapping; with bit 13 at 0 the byte order is unchanged.
- R9: A cycle with xfer_req high produces stat_valid high and the formatted word on stat_word in the next cycle; back-to-back requests produce back-to-back words.
- R10: hint64 follows bit 17 and hint32 follows bit 10; neither changes interrupts or the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 32 | Read data (combinational) |
| src1 | input | 32 | Interrupt source vector 1 |
| mask1 | input | 32 | Enable mask for source 1 |
| src2 | input | 32 | Interrupt source vector 2 |
| mask2 | input | 32 | Enable mask for source 2 |
| xfer_req | input | 1 | Request a status word |
| irq1 | output | 1 | Hardware interrupt line 1 |
| irq2 | output | 1 | Hardware interrupt line 2 |
| stat_word | output | 64 | Formatted status word |
| stat_valid | output | 1 | Status word strobe |
| hint64 | output | 1 | 64-bit target hint |
| hint32 | output | 1 | 32-bit target hint |

## Verification
The status word is requested with distinct byte values in every lane of both sources and with masks that cut different bytes. This lets the test distinguish raw from masked halves, swapped from natural order, and reversed from straight byte order, in each combination reached by setting and clearing control bits. The interrupt lines are tested with only source 1 active, then only source 2, then with merging on and an enable removed, which separates routing from enabling. Writes with only high data bits and writes to an unused offset must leave the readback unchanged.

// File: rtl/irqctl_pkg.sv
package irqctl_pkg;

    localparam int CTRL_W  = 18;
    localparam int WORD_W  = 32;
    localparam int BYTES_W = WORD_W / 8;
    localparam int NSRC    = 2;

    localparam logic [CTRL_W-1:0] CTRL_RST = 18'h10200;

    localparam int B_HINT64 = 17;
    localparam int B_SWAP   = 16;
    localparam int B_EN1    = 15;
    localparam int B_EN2    = 14;
    localparam int B_LITTLE = 13;
    localparam int B_ROUTE  = 12;
    localparam int B_MASKED = 11;
    localparam int B_HINT32 = 10;

    typedef struct packed {
        logic hint64;
        logic swap;
        logic en1;
        logic en2;
        logic little;
        logic route;
        logic masked;
        logic hint32;
    } ctrl_view_t;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } dword_t;

    function automatic ctrl_view_t decode_ctrl(input logic [CTRL_W-1:0] c);
        ctrl_view_t v;
        v.hint64 = c[B_HINT64];
        v.swap   = c[B_SWAP];
        v.en1    = c[B_EN1];
        v.en2    = c[B_EN2];
        v.little = c[B_LITTLE];
        v.route  = c[B_ROUTE];
        v.masked = c[B_MASKED];
        v.hint32 = c[B_HINT32];
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < BYTES_W; i++) begin
            r[8*i +: 8] = w[WORD_W-8-8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/irqctl_regfile.sv
module irqctl_regfile
    import irqctl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] SET_OFF = 4'h8,
    parameter logic [ADDR_W-1:0] CLR_OFF = 4'hC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTRL_W-1:0] wr_bits,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [CTRL_W-1:0] ctrl_q
);

    localparam int PAD_W = WORD_W - CTRL_W;

    logic do_set;
    logic do_clr;
    logic [CTRL_W-1:0] ctrl_d;

    assign do_set = wr_en && (wr_addr == SET_OFF);
    assign do_clr = wr_en && (wr_addr == CLR_OFF);

    always_comb begin
        ctrl_d = ctrl_q;
        if (do_set) ctrl_d = ctrl_q | wr_bits;
        else if (do_clr) ctrl_d = ctrl_q & ~wr_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= CTRL_RST;
        else     ctrl_q <= ctrl_d;
    end

    always_comb begin
        if (rd_addr == SET_OFF || rd_addr == CLR_OFF)
            rd_data = {{PAD_W{1'b0}}, ctrl_q};
        else
            rd_data = '0;
    end

endmodule

// File: rtl/irqctl_route.sv
module irqctl_route
    import irqctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en1,
    input  logic              en2,
    input  logic              route,
    input  logic [WORD_W-1:0] src1,
    input  logic [WORD_W-1:0] mask1,
    input  logic [WORD_W-1:0] src2,
    input  logic [WORD_W-1:0] mask2,
    output logic              irq1,
    output logic              irq2
);

    logic [WORD_W-1:0] src_a  [NSRC];
    logic [WORD_W-1:0] mask_a [NSRC];
    logic [NSRC-1:0]   en_a;
    logic [NSRC-1:0]   live;

    assign src_a[0]  = src1;
    assign src_a[1]  = src2;
    assign mask_a[0] = mask1;
    assign mask_a[1] = mask2;
    assign en_a      = {en2, en1};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign live[g] = en_a[g] & (|(src_a[g] & mask_a[g]));
    end

    logic irq1_d;
    logic irq2_d;

    always_comb begin
        if (route) begin
            irq1_d = |live;
            irq2_d = 1'b0;
        end else begin
            irq1_d = live[0];
            irq2_d = live[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq1 <= 1'b0;
            irq2 <= 1'b0;
        end else begin
            irq1 <= irq1_d;
            irq2 <= irq2_d;
        end
    end

endmodule

// File: rtl/irqctl_fmt.sv
module irqctl_fmt
    import irqctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              masked,
    input  logic              swap,
    input  logic              little,
    input  logic [WORD_W-1:0] src1,
    input  logic [WORD_W-1:0] mask1,
    input  logic [WORD_W-1:0] src2,
    input  logic [WORD_W-1:0] mask2,
    input  logic              xfer_req,
    output logic [2*WORD_W-1:0] stat_word,
    output logic              stat_valid
);

    dword_t natural_w;
    dword_t swapped_w;
    dword_t final_w;

    // stage 1: masking
    assign natural_w.hi = masked ? (src1 & mask1) : src1;
    assign natural_w.lo = masked ? (src2 & mask2) : src2;

    // stage 2: half exchange
    assign swapped_w = swap ? '{hi: natural_w.lo, lo: natural_w.hi} : natural_w;

    // stage 3: byte order within each half
    assign final_w.hi = little ? byte_rev(swapped_w.hi) : swapped_w.hi;
    assign final_w.lo = little ? byte_rev(swapped_w.lo) : swapped_w.lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_word  <= '0;
            stat_valid <= 1'b0;
        end else begin
            stat_valid <= xfer_req;
            if (xfer_req) stat_word <= final_w;
        end
    end

endmodule

// File: rtl/irqctl_top.sv
module irqctl_top
    import irqctl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] SET_OFF = 4'h8,
    parameter logic [ADDR_W-1:0] CLR_OFF = 4'hC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [31:0]       src1,
    input  logic [31:0]       mask1,
    input  logic [31:0]       src2,
    input  logic [31:0]       mask2,
    input  logic              xfer_req,
    output logic              irq1,
    output logic              irq2,
    output logic [63:0]       stat_word,
    output logic              stat_valid,
    output logic              hint64,
    output logic              hint32
);

    logic [CTRL_W-1:0] ctrl_q;
    ctrl_view_t        view;

    assign view = decode_ctrl(ctrl_q);

    irqctl_regfile #(
        .ADDR_W (ADDR_W),
        .SET_OFF(SET_OFF),
        .CLR_OFF(CLR_OFF)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_bits(wr_data[CTRL_W-1:0]),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .ctrl_q (ctrl_q)
    );

    irqctl_route u_route (
        .clk  (clk),
        .rst  (rst),
        .en1  (view.en1),
        .en2  (view.en2),
        .route(view.route),
        .src1 (src1),
        .mask1(mask1),
        .src2 (src2),
        .mask2(mask2),
        .irq1 (irq1),
        .irq2 (irq2)
    );

    irqctl_fmt u_fmt (
        .clk       (clk),
        .rst       (rst),
        .masked    (view.masked),
        .swap      (view.swap),
        .little    (view.little),
        .src1      (src1),
        .mask1     (mask1),
        .src2      (src2),
        .mask2     (mask2),
        .xfer_req  (xfer_req),
        .stat_word (stat_word),
        .stat_valid(stat_valid)
    );

    assign hint64 = view.hint64;
    assign hint32 = view.hint32;

endmodule

// File: rtl/irqctl_chk.sv
module irqctl_chk
    import irqctl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] SET_OFF = 4'h8,
    parameter logic [ADDR_W-1:0] CLR_OFF = 4'hC
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data,
    input logic              xfer_req,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              irq1,
    input logic              irq2,
    input logic              stat_valid
);

    // R2: set address leaves every written one bit at 1
    p_set_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == SET_OFF) |=>
            ((ctrl_q & $past(wr_data[CTRL_W-1:0])) == $past(wr_data[CTRL_W-1:0])));

    // R2: clear address leaves every written one bit at 0
    p_clr_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == CLR_OFF) |=> ((ctrl_q & $past(wr_data[CTRL_W-1:0])) == '0));

    // R2: no matching write, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_addr == SET_OFF || wr_addr == CLR_OFF)) |=> $stable(ctrl_q));

    // R3: upper read bits are always zero
    p_rd_pad_r3: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:CTRL_W] == '0);

    // R4: both enables off keeps both lines low
    p_disabled_r4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[B_EN1] && !ctrl_q[B_EN2]) |=> (!irq1 && !irq2));

    // R5: merged routing silences line 2
    p_route_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        irq2 |-> !$past(ctrl_q[B_ROUTE]));

    // R9: every strobe follows a request
    p_valid_src_r9: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> $past(xfer_req));

endmodule

bind irqctl_top irqctl_chk #(
    .ADDR_W (ADDR_W),
    .SET_OFF(SET_OFF),
    .CLR_OFF(CLR_OFF)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .xfer_req  (xfer_req),
    .ctrl_q    (ctrl_q),
    .irq1      (irq1),
    .irq2      (irq2),
    .stat_valid(stat_valid)
);

// File: tb/sim_irqctl_top.sv
`timescale 1ns/1ps
module sim_irqctl_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] src1 = '0, mask1 = '0, src2 = '0, mask2 = '0;
    logic        xfer_req = 1'b0;
    logic        irq1, irq2, stat_valid, hint64, hint32;
    logic [63:0] stat_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [17:0] mctl = 18'h10200;
    logic [63:0] sb_q[$];

    always #2.5 clk = ~clk;

    irqctl_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .src1(src1), .mask1(mask1),
        .src2(src2), .mask2(mask2), .xfer_req(xfer_req), .irq1(irq1), .irq2(irq2),
        .stat_word(stat_word), .stat_valid(stat_valid), .hint64(hint64), .hint32(hint32)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [63:0] model_word(input logic [17:0] c);
        logic [31:0] a, b, h, l;
        a = c[11] ? (src1 & mask1) : src1;
        b = c[11] ? (src2 & mask2) : src2;
        if (c[16]) begin h = b; l = a; end else begin h = a; l = b; end
        if (c[13]) begin h = rev(h); l = rev(l); end
        return {h, l};
    endfunction

    task automatic write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 4'h8) mctl = mctl | d[17:0];
        else if (a == 4'hC) mctl = mctl & ~d[17:0];
    endtask

    task automatic readback(input string req, input logic [3:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(req, {32'h0, rd_data}, {32'h0, exp});
    endtask

    // driver: push expected word, raise request for one cycle
    task automatic request(input logic [31:0] s1, input logic [31:0] m1,
                           input logic [31:0] s2, input logic [31:0] m2);
        src1 = s1; mask1 = m1; src2 = s2; mask2 = m2;
        xfer_req = 1'b1;
        sb_q.push_back(model_word(mctl));
        @(negedge clk);
        xfer_req = 1'b0;
    endtask

    task automatic irq_check(input string req, input logic e1, input logic e2);
        @(negedge clk);
        chk(req, {62'h0, irq1, irq2}, {62'h0, e1, e2});
    endtask

    // monitor: compare each produced word against the scoreboard
    always @(negedge clk) begin
        if (!rst && stat_valid) begin
            if (sb_q.size() == 0) chk("R9 unexpected strobe", 64'h1, 64'h0);
            else chk("R6-R8 status word", stat_word, sb_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 / R3 reset state and readback
        readback("R1 reset value", 4'h8, 32'h0001_0200);
        readback("R3 clear offset reads word", 4'hC, 32'h0001_0200);
        readback("R3 other offset reads zero", 4'h0, 32'h0);
        chk("R1 outputs idle", {60'h0, irq1, irq2, stat_valid, hint64}, 64'h0);
        chk("R10 hint32 reset", {63'h0, hint32}, 64'h0);

        // R7 default swap, raw words (R6)
        @(negedge clk);
        request(32'h1122_3344, 32'h0000_FFFF, 32'hAABB_CCDD, 32'hFF00_FF00);
        // R6 masked
        write(4'h8, 32'h0000_0800);
        readback("R2 set bit 11", 4'h8, 32'h0001_0A00);
        request(32'h1122_3344, 32'h0000_FFFF, 32'hAABB_CCDD, 32'hFF00_FF00);
        // R7 no swap
        write(4'hC, 32'h0001_0000);
        readback("R2 clear bit 16", 4'hC, 32'h0000_0A00);
        request(32'h5566_7788, 32'hFFFF_0000, 32'h99AA_BBCC, 32'h00FF_00FF);
        // R8 little endian
        write(4'h8, 32'h0000_2000);
        request(32'h0102_0304, 32'hFFFF_FFFF, 32'hA1B2_C3D4, 32'h0F0F_F0F0);
        write(4'h8, 32'h0001_0000);
        request(32'h0102_0304, 32'hFFFF_FF00, 32'hA1B2_C3D4, 32'hFFFF_FFFF);
        // R9 back-to-back requests
        src1 = 32'hDEAD_BEEF; mask1 = '1; src2 = 32'h0BAD_F00D; mask2 = '1;
        xfer_req = 1'b1;
        sb_q.push_back(model_word(mctl));
        @(negedge clk);
        src1 = 32'hCAFE_0001;
        sb_q.push_back(model_word(mctl));
        @(negedge clk);
        xfer_req = 1'b0;
        @(negedge clk);
        chk("R9 strobe drops", {63'h0, stat_valid}, 64'h0);

        // R2 ignored writes
        write(4'h8, 32'hFFFC_0000);
        readback("R2 high data bits ignored", 4'h8, {14'h0, mctl});
        write(4'h4, 32'h0003_FFFF);
        readback("R2 other offset ignored", 4'h8, {14'h0, mctl});
        write(4'h0, 32'h0003_FFFF);
        readback("R2 offset zero ignored", 4'hC, 32'h0001_2A00);

        // R4 interrupts
        src1 = 32'h0000_0010; mask1 = 32'h0000_0010; src2 = '0; mask2 = '1;
        irq_check("R4 disabled lines low", 1'b0, 1'b0);
        write(4'h8, 32'h0000_C000);
        irq_check("R4 source 1 only", 1'b1, 1'b0);
        src1 = 32'h0000_0010; mask1 = 32'h0000_0001; src2 = 32'h8000_0000;
        irq_check("R4 source 2 only", 1'b0, 1'b1);
        // R5 routing
        write(4'h8, 32'h0000_1000);
        irq_check("R5 merged onto line 1", 1'b1, 1'b0);
        write(4'hC, 32'h0000_4000);
        irq_check("R5 enable 2 removed", 1'b0, 1'b0);
        write(4'hC, 32'h0000_1000);
        mask1 = 32'h0000_0010;
        irq_check("R4 unrouted source 1", 1'b1, 1'b0);

        // R10 hints
        write(4'h8, 32'h0002_0400);
        @(negedge clk);
        chk("R10 hints follow bits", {62'h0, hint64, hint32}, 64'h3);
        irq_check("R10 hints no irq effect", 1'b1, 1'b0);
        request(32'h1357_9BDF, 32'hF0F0_F0F0, 32'h2468_ACE0, 32'h0FF0_0FF0);
        write(4'hC, 32'h0002_0400);
        @(negedge clk);
        chk("R10 hints cleared", {62'h0, hint64, hint32}, 64'h0);

        repeat (2) @(negedge clk);
        chk("R9 all words produced", 64'(sb_q.size()), 64'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule